// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Shortcut Bits

The controller gathers level-sensitive interrupt lines from three banks. The basic bank has 8 sources. Each of the two peripheral banks has 32 sources. Every bank has a mask. Software sets the mask bits by writing ones to an enable address and clears them by writing ones to a disable address. Each bank's status word reads as the raw lines ANDed with that bank's mask.

The basic bank's status word also serves as a top-level view. Bit 8 flags any enabled and pending source in peripheral bank 1 that has no shortcut, and bit 9 does the same for peripheral bank 2. A fixed set of peripheral sources also appears directly as shortcut bits 10 to 20. Those shortcut sources are left out of the summary bits. They can be masked only through their own bank's mask.

A single interrupt output is raised whenever any visible bit 0 to 20 of the basic status word is set. Register access uses a plain 32-bit bus with separate write and read strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_tri_bank_ctrl`

## Requirements
- R1: After reset all three masks are zero, every status and mask read returns 0, and `irq_out` is low, even when every source line is high.
- R2: A write to 0x18 (bank 0), 0x10 (bank 1) or 0x14 (bank 2) sets the mask bit of each source whose data bit is 1. Data bits that are 0 leave the mask unchanged. Reading the same address returns the current mask.
- R3: A write to 0x24 (bank 0), 0x1C (bank 1) or 0x20 (bank 2) clears the mask bit of each source whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R4: A read of 0x04 (bank 1) or 0x08 (bank 2) returns the raw source lines of that bank ANDed with the bank's mask, with source n in data bit n.
- R5: Bits 0 to 7 of a read of 0x00 are the bank 0 source lines ANDed with the bank 0 mask.
- R6: Bit 8 at 0x00 is set when any bank 1 source other than 7, 9, 10, 18 and 19 is both pending and enabled. Bit 9 is set in the same way for bank 2 sources other than 21 to 25 and 30.
- R7: Bits 10 to 14 at 0x00 show the masked bank 1 sources 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 show the masked bank 2 sources 21, 22, 23, 24, 25 and 30, in that order. These sources still appear in their own bank's status word, and they never set bit 8 or bit 9.
- R8: Data bits 8 to 31 written to 0x18 or 0x24 have no effect. Such writes leave the bank 1 and bank 2 masks unchanged, and bits 8 to 31 of a read of 0x18 are 0.
- R9: `irq_out` is the OR of bits 0 to 20 of the bank 0 status word. It follows source and mask changes without a register stage.
- R10: `bus_rdata` is loaded on the clock edge at which `bus_rd` is high and holds its value at all other times. Unmapped addresses and the disable addresses read 0, and bits 21 to 31 of 0x00 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_b0 | input | 8 | Raw level lines of bank 0 |
| src_b1 | input | 32 | Raw level lines of peripheral bank 1 |
| src_b2 | input | 32 | Raw level lines of peripheral bank 2 |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions check four rules on every cycle:
- enable writes set the written bits and disable writes clear them;
- writes to the bank 0 mask addresses never move the peripheral masks;
- a read of the basic status word shows no bank 1 summary while only shortcut sources of bank 1 are high;
- the output is quiet with all lines low, and read data holds between reads.

Some behaviour only the bench scenarios can show: the exact bit positions and order of the shortcut copies, the summary bit appearing for a non-shortcut source, the masking of the output through the disable path, and the zero reads of unmapped and disable addresses.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned B0_SRC   = 8;
    localparam int unsigned BP_SRC   = 32;
    localparam int unsigned SC1_N    = 5;
    localparam int unsigned SC2_N    = 6;
    localparam int unsigned SUM1_BIT = B0_SRC;
    localparam int unsigned SUM2_BIT = B0_SRC + 1;
    localparam int unsigned SC1_LSB  = B0_SRC + 2;
    localparam int unsigned SC2_LSB  = SC1_LSB + SC1_N;
    localparam int unsigned ST0_W    = SC2_LSB + SC2_N;

    // register byte offsets
    localparam int unsigned OFF_ST0  = 'h00;
    localparam int unsigned OFF_ST1  = 'h04;
    localparam int unsigned OFF_ST2  = 'h08;
    localparam int unsigned OFF_EN1  = 'h10;
    localparam int unsigned OFF_EN2  = 'h14;
    localparam int unsigned OFF_EN0  = 'h18;
    localparam int unsigned OFF_DIS1 = 'h1C;
    localparam int unsigned OFF_DIS2 = 'h20;
    localparam int unsigned OFF_DIS0 = 'h24;

    // source number carried by shortcut slot k of a peripheral bank
    function automatic int unsigned sc_src(input int unsigned bank, input int unsigned k);
        int unsigned r;
        r = 0;
        if (bank == 1) begin
            case (k)
                0: r = 7;
                1: r = 9;
                2: r = 10;
                3: r = 18;
                default: r = 19;
            endcase
        end else begin
            if (k < 5) r = 21 + k;
            else       r = 30;
        end
        return r;
    endfunction

    function automatic int unsigned sc_count(input int unsigned bank);
        return (bank == 1) ? SC1_N : SC2_N;
    endfunction

    function automatic logic [BP_SRC-1:0] sc_mask(input int unsigned bank);
        logic [BP_SRC-1:0] m;
        m = '0;
        for (int unsigned k = 0; k < sc_count(bank); k++) begin
            m[sc_src(bank, k)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int unsigned SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [SRC_W-1:0] wbits,
    input  logic [SRC_W-1:0] raw,
    output logic [SRC_W-1:0] en_q,
    output logic [SRC_W-1:0] pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (set_we) begin
            en_q <= en_q | wbits;
        end else if (clr_we) begin
            en_q <= en_q & ~wbits;
        end
    end

    assign pend = raw & en_q;

endmodule

// File: rtl/irqc_sc_map.sv
module irqc_sc_map
    import irqc_pkg::*;
#(
    parameter int unsigned BANK  = 1,
    parameter int unsigned SRC_W = 32,
    parameter int unsigned SC_N  = 5
) (
    input  logic [SRC_W-1:0] pend,
    output logic [SC_N-1:0]  sc,
    output logic             summary
);

    localparam logic [SRC_W-1:0] SC_MASK = SRC_W'(sc_mask(BANK));

    for (genvar k = 0; k < SC_N; k++) begin : g_sc
        assign sc[k] = pend[sc_src(BANK, k)];
    end

    assign summary = |(pend & ~SC_MASK);

endmodule

// File: rtl/irqc_regdec.sv
module irqc_regdec
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        set_we,
    output logic [2:0]        clr_we
);

    always_comb begin
        set_we = '0;
        clr_we = '0;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFF_EN0):  set_we[0] = 1'b1;
                ADDR_W'(OFF_EN1):  set_we[1] = 1'b1;
                ADDR_W'(OFF_EN2):  set_we[2] = 1'b1;
                ADDR_W'(OFF_DIS0): clr_we[0] = 1'b1;
                ADDR_W'(OFF_DIS1): clr_we[1] = 1'b1;
                ADDR_W'(OFF_DIS2): clr_we[2] = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_tri_bank_ctrl.sv
module irq_tri_bank_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [B0_SRC-1:0] src_b0,
    input  logic [BP_SRC-1:0] src_b1,
    input  logic [BP_SRC-1:0] src_b2,
    output logic              irq_out
);

    logic [2:0]        set_we;
    logic [2:0]        clr_we;
    logic [B0_SRC-1:0] en0_q;
    logic [B0_SRC-1:0] pend0;
    logic [BP_SRC-1:0] en1_q;
    logic [BP_SRC-1:0] pend1;
    logic [BP_SRC-1:0] en2_q;
    logic [BP_SRC-1:0] pend2;
    logic [SC1_N-1:0]  sc1;
    logic [SC2_N-1:0]  sc2;
    logic              sum1;
    logic              sum2;
    logic [ST0_W-1:0]  status0;
    logic [DATA_W-1:0] rd_mux;

    irqc_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .set_we   (set_we),
        .clr_we   (clr_we)
    );

    irqc_bank #(.SRC_W(B0_SRC)) u_bank0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (set_we[0]),
        .clr_we (clr_we[0]),
        .wbits  (bus_wdata[B0_SRC-1:0]),
        .raw    (src_b0),
        .en_q   (en0_q),
        .pend   (pend0)
    );

    irqc_bank #(.SRC_W(BP_SRC)) u_bank1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (set_we[1]),
        .clr_we (clr_we[1]),
        .wbits  (bus_wdata[BP_SRC-1:0]),
        .raw    (src_b1),
        .en_q   (en1_q),
        .pend   (pend1)
    );

    irqc_bank #(.SRC_W(BP_SRC)) u_bank2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (set_we[2]),
        .clr_we (clr_we[2]),
        .wbits  (bus_wdata[BP_SRC-1:0]),
        .raw    (src_b2),
        .en_q   (en2_q),
        .pend   (pend2)
    );

    irqc_sc_map #(.BANK(1), .SRC_W(BP_SRC), .SC_N(SC1_N)) u_map1 (
        .pend    (pend1),
        .sc      (sc1),
        .summary (sum1)
    );

    irqc_sc_map #(.BANK(2), .SRC_W(BP_SRC), .SC_N(SC2_N)) u_map2 (
        .pend    (pend2),
        .sc      (sc2),
        .summary (sum2)
    );

    assign status0 = {sc2, sc1, sum2, sum1, pend0};
    assign irq_out = |status0;

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFF_ST0): rd_mux = DATA_W'(status0);
            ADDR_W'(OFF_ST1): rd_mux = DATA_W'(pend1);
            ADDR_W'(OFF_ST2): rd_mux = DATA_W'(pend2);
            ADDR_W'(OFF_EN0): rd_mux = DATA_W'(en0_q);
            ADDR_W'(OFF_EN1): rd_mux = DATA_W'(en1_q);
            ADDR_W'(OFF_EN2): rd_mux = DATA_W'(en2_q);
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [B0_SRC-1:0] src_b0,
    input logic [BP_SRC-1:0] src_b1,
    input logic [BP_SRC-1:0] src_b2,
    input logic              irq_out,
    input logic [BP_SRC-1:0] en1_q,
    input logic [BP_SRC-1:0] en2_q
);

    localparam logic [BP_SRC-1:0] M1 = sc_mask(1);

    a_r2_set_bank1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EN1)) |=>
        ((en1_q & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_clear_bank2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_DIS2)) |=>
        ((en2_q & $past(bus_wdata)) == '0));

    a_r8_bank0_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(OFF_EN0) || bus_addr == ADDR_W'(OFF_DIS0))) |=>
        ($stable(en1_q) && $stable(en2_q)));

    a_r7_shortcut_no_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_ST0) && ((src_b1 & ~M1) == '0)) |=>
        (bus_rdata[SUM1_BIT] == 1'b0));

    a_r9_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (src_b0 == '0 && src_b1 == '0 && src_b2 == '0) |-> !irq_out);

    a_r10_hold_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind irq_tri_bank_ctrl irqc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_b0    (src_b0),
    .src_b1    (src_b1),
    .src_b2    (src_b2),
    .irq_out   (irq_out),
    .en1_q     (en1_q),
    .en2_q     (en2_q)
);

// File: tb/test_irq_tri_bank_ctrl.sv
`timescale 1ns/1ps
module test_irq_tri_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  src_b0 = '1;
    logic [31:0] src_b1 = '1;
    logic [31:0] src_b2 = '1;
    logic        irq_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic rd_fire = 1'b0;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [7:0]  m_en0 = '0;
    logic [31:0] m_en1 = '0;
    logic [31:0] m_en2 = '0;

    always #10 clk = ~clk;

    irq_tri_bank_ctrl i_irq_tri_bank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_b0    (src_b0),
        .src_b1    (src_b1),
        .src_b2    (src_b2),
        .irq_out   (irq_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected basic status word, built from R5, R6 and R7
    function automatic logic [31:0] exp_st0();
        logic [31:0] v;
        logic [31:0] p1;
        logic [31:0] p2;
        p1 = src_b1 & m_en1;
        p2 = src_b2 & m_en2;
        v = '0;
        v[7:0] = src_b0 & m_en0;
        v[8]  = |(p1 & ~32'h000C_0680);
        v[9]  = |(p2 & ~32'h43E0_0000);
        v[10] = p1[7];
        v[11] = p1[9];
        v[12] = p1[10];
        v[13] = p1[18];
        v[14] = p1[19];
        v[15] = p2[21];
        v[16] = p2[22];
        v[17] = p2[23];
        v[18] = p2[24];
        v[19] = p2[25];
        v[20] = p2[30];
        return v;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        case (a)
            6'h00:   return exp_st0();
            6'h04:   return src_b1 & m_en1;
            6'h08:   return src_b2 & m_en2;
            6'h10:   return m_en1;
            6'h14:   return m_en2;
            6'h18:   return {24'h0, m_en0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        case (a)
            6'h18: m_en0 = m_en0 | d[7:0];
            6'h10: m_en1 = m_en1 | d;
            6'h14: m_en2 = m_en2 | d;
            6'h24: m_en0 = m_en0 & ~d[7:0];
            6'h1C: m_en1 = m_en1 & ~d;
            6'h20: m_en2 = m_en2 & ~d;
            default: ;
        endcase
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        exp_t e;
        bus_rd = 1'b1;
        bus_addr = a;
        e.v = exp_rd(a);
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input string tag);
        logic exp;
        logic [31:0] s;
        s = exp_st0();
        exp = |s[20:0];
        chk({31'h0, irq_out}, {31'h0, exp}, tag);
    endtask

    // monitor: compare each read result against the scoreboard
    always @(posedge clk) rd_fire <= bus_rd;

    always @(negedge clk) begin
        if (rd_fire) begin
            if (exp_q.size() == 0) begin
                chk(bus_rdata, 32'hDEAD_BEEF, "scoreboard-empty");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(bus_rdata, e.v, e.tag);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk_irq("R1 irq in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_irq("R1 irq after reset");
        rd(6'h00, "R1 status0");
        rd(6'h04, "R1 status1");
        rd(6'h08, "R1 status2");
        rd(6'h18, "R1 enable0");
        rd(6'h10, "R1 enable1");
        rd(6'h14, "R1 enable2");

        src_b1 = '0;
        src_b2 = '0;
        src_b0 = 8'h3C;
        wr(6'h18, 32'h0000_00A5);
        rd(6'h18, "R2 enable0 readback");
        rd(6'h00, "R5 bank0 masked status");
        chk_irq("R9 bank0 source");

        wr(6'h24, 32'h0000_0005);
        rd(6'h18, "R3 enable0 after disable");
        rd(6'h00, "R5 bank0 after disable");

        wr(6'h18, 32'hFFFF_FF00);
        rd(6'h18, "R8 enable0 high bits ignored");
        rd(6'h10, "R8 enable1 untouched");
        rd(6'h14, "R8 enable2 untouched");

        src_b0 = '0;
        wr(6'h24, 32'h0000_00FF);
        chk_irq("R9 all quiet");

        src_b1 = 32'h0000_0008;
        wr(6'h10, 32'h0000_000F);
        wr(6'h10, 32'h0000_0000);
        rd(6'h10, "R2 zero write keeps enable1");
        rd(6'h04, "R4 bank1 status");
        rd(6'h00, "R6 summary bit8");
        chk_irq("R9 summary source");

        src_b1 = 32'h0000_0080;
        wr(6'h10, 32'h0000_0080);
        rd(6'h00, "R7 shortcut bit10 no bit8");
        rd(6'h04, "R7 shortcut in own bank");
        chk_irq("R9 shortcut source");

        wr(6'h1C, 32'h0000_0080);
        rd(6'h00, "R3 shortcut disabled in bank1");
        chk_irq("R9 masked shortcut");

        src_b1 = '0;
        src_b2 = 32'h43E0_0001;
        wr(6'h14, 32'hFFFF_FFFF);
        rd(6'h00, "R7 bank2 shortcuts with bit9");
        rd(6'h08, "R4 bank2 status");

        src_b2 = 32'h43E0_0000;
        rd(6'h00, "R7 bank2 shortcuts no bit9");

        wr(6'h24, 32'hFFFF_FFFF);
        rd(6'h14, "R8 bank0 disable keeps enable2");
        rd(6'h00, "R8 shortcuts survive bank0 disable");

        src_b2 = 32'h4000_0000;
        rd(6'h00, "R7 source30 on bit20");
        wr(6'h20, 32'h4000_0000);
        chk_irq("R9 bank2 shortcut masked");

        rd(6'h0C, "R10 unmapped 0x0C");
        rd(6'h28, "R10 unmapped 0x28");
        rd(6'h1C, "R10 disable addr reads zero");
        rd(6'h14, "R10 enable2 before hold");
        @(negedge clk);
        chk(bus_rdata, 32'hBFFF_FFFF, "R10 rdata held");

        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule